// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire management bus used to reach Ethernet PHYs. Software sets up four 32-bit registers (configuration, address, data and operation) through a simple synchronous write/read port. A write to the operation register launches one management frame; a busy flag in that register stays high until the frame's last bit has been clocked out. Both the classic direct-addressing framing and the indirect, extended-addressing framing are supported, and one configuration bit selects between them.

The management clock is derived from the core clock by a programmable divider and stays low while no frame is running. The data line is driven through an output and an output-enable pin so that it can be tri-stated outside the block. On read frames the line is released for the turnaround and the 16 data bits. Each data bit is sampled on a rising clock edge and the resulting word is placed in the data register. An optional 32-bit preamble, an enable for the sampled input and an inversion of the sampled input are also configurable.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset all four registers read as zero, busy is clear, `mdc` is low and `mdio_oe` is low.
- R2: While a frame runs, `mdc` has a period of 2*(div+1) core clocks, where div is configuration bits [12:5]; `mdc` is low whenever no frame runs.
- R3: A frame is sent MSB first, one bit per `mdc` period, with bits changing after `mdc` falls: optional preamble of 32 ones (configuration bit 2), start code 01 (configuration bit 3 clear) or 00 (bit 3 set), the 2-bit opcode, PHY address from address bits [9:5], register/device address from address bits [4:0], turnaround 10 on non-read frames, then 16 bits from data bits [15:0] (for a non-read frame).
- R4: The opcode is written to operation bits [1:0] and is sent as-is. With configuration bit 3 set, 0 is an address frame, 1 a write, and 2 and 3 are reads. With bit 3 clear, 1 is a write and 2 a read; 0 and 3 start nothing.
- R5: Operation bit 31 reads 1 from the cycle after an accepted opcode write until the frame ends; `mdio_oe` is low while it is 0.
- R6: A write to the operation register while busy is set is ignored: the running frame and the stored opcode are unchanged.
- R7: On a read frame `mdio_oe` is low for the two turnaround bits and the 16 data bits. The 16 bits sampled on the `mdc` rising edges are stored, MSB first, in data bits [15:0] when the frame ends. Data bits [31:16] read as 0.
- R8: Each sampled bit equals `mdio_i` XOR configuration bit 1 when configuration bit 0 is set, and 0 when bit 0 is clear.
- R9: Register select 0 = configuration, 1 = address, 2 = data, 3 = operation. Configuration reads back bits [3:0] and [12:5] (bit 4 reads 0), address reads back bits [9:0], and data reads back bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Registered read data, one cycle after `rd_sel` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that software leaves the configuration register, in particular the divider field, unchanged while busy is set. The minimum-high-phase check of `mdc` would otherwise be able to fail on a legal mid-frame reprogramming. They also assume `mdio_i` is stable around the sampling edge. The bench writes configuration only while the block is idle. Its PHY model changes `mdio_i` only just after an observed `mdc` rise, so every value is held for at least a full low phase before the next sampling edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_OP   = 2'd3
  } reg_sel_e;

  localparam int CFG_MDI_EN  = 0;
  localparam int CFG_MDI_INV = 1;
  localparam int CFG_PRE_EN  = 2;
  localparam int CFG_EXT     = 3;
  localparam int CFG_RSVD    = 4;
  localparam int CFG_DIV_LSB = 5;

  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int TA_BITS    = 2;
  localparam int BUSY_BIT   = 31;
endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            mdc,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt;
  logic            wrap;

  assign wrap = (cnt == div);
  assign rise = run && wrap && !mdc;
  assign fall = run && wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdm_engine.sv
module mdm_engine
  import mdm_pkg::*;
#(
  parameter int PREW = PRE_BITS,
  parameter int FRMW = FRAME_BITS,
  parameter int DATW = DATA_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_read,
  input  logic            pre_en,
  input  logic [FRMW-1:0] frame_word,
  input  logic            rise,
  input  logic            fall,
  input  logic            mdi_bit,
  output logic            busy,
  output logic            rd_op,
  output logic            done,
  output logic [DATW-1:0] rd_capt,
  output logic            mdio_o,
  output logic            mdio_oe
);
  localparam int SHW = PREW + FRMW;
  localparam int LW  = $clog2(SHW + 1);
  localparam logic [LW-1:0] LEFT_FULL  = LW'(SHW);
  localparam logic [LW-1:0] LEFT_SHORT = LW'(FRMW);
  localparam logic [LW-1:0] LEFT_DATA  = LW'(DATW);
  localparam logic [LW-1:0] LEFT_REL   = LW'(DATW + TA_BITS);

  logic [SHW-1:0] shreg;
  logic [LW-1:0]  left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rd_op   <= 1'b0;
      done    <= 1'b0;
      shreg   <= '0;
      left    <= '0;
      rd_capt <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        rd_op <= start_read;
        if (pre_en) begin
          shreg <= {{PREW{1'b1}}, frame_word};
          left  <= LEFT_FULL;
        end else begin
          shreg <= {frame_word, {PREW{1'b0}}};
          left  <= LEFT_SHORT;
        end
      end else if (busy) begin
        if (rise && rd_op && (left <= LEFT_DATA))
          rd_capt <= {rd_capt[DATW-2:0], mdi_bit};
        if (fall) begin
          if (left == LW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          left  <= left - 1'b1;
          shreg <= {shreg[SHW-2:0], 1'b0};
        end
      end
    end
  end

  assign mdio_o  = shreg[SHW-1];
  assign mdio_oe = busy && !(rd_op && (left <= LEFT_REL));
endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
  import mdm_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CFGW = CFG_DIV_LSB + DIVW;
  localparam logic [CFGW-1:0] CFG_KEEP = ~({{(CFGW-1){1'b0}}, 1'b1} << CFG_RSVD);

  logic [CFGW-1:0]      cfg_q;
  logic [9:0]           addr_q;
  logic [DATA_BITS-1:0] data_q;
  logic [1:0]           op_q;

  logic                 busy, rd_op, done, rise, fall;
  logic [DATA_BITS-1:0] rd_capt;
  logic [FRAME_BITS-1:0] frame_word;
  logic                 cfg_ext, op_wr, op_legal, start, start_read, mdi_bit;
  logic [DIVW-1:0]      div_q;

  assign cfg_ext    = cfg_q[CFG_EXT];
  assign div_q      = cfg_q[CFGW-1:CFG_DIV_LSB];
  assign op_wr      = wr_en && (reg_sel_e'(wr_sel) == SEL_OP);
  assign op_legal   = cfg_ext || (wr_data[1:0] == 2'd1) || (wr_data[1:0] == 2'd2);
  assign start      = op_wr && !busy && op_legal;
  assign start_read = wr_data[1];
  assign mdi_bit    = cfg_q[CFG_MDI_EN] & (mdio_i ^ cfg_q[CFG_MDI_INV]);

  always_comb begin
    frame_word = {cfg_ext ? 2'b00 : 2'b01,
                  wr_data[1:0],
                  addr_q[9:5],
                  addr_q[4:0],
                  start_read ? 2'b11 : 2'b10,
                  start_read ? {DATA_BITS{1'b1}} : data_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      op_q   <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_CFG:  cfg_q  <= wr_data[CFGW-1:0] & CFG_KEEP;
          SEL_ADDR: addr_q <= wr_data[9:0];
          SEL_DATA: data_q <= wr_data[DATA_BITS-1:0];
          default:  ;
        endcase
      end
      if (start)
        op_q <= wr_data[1:0];
      if (done && rd_op)
        data_q <= rd_capt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_sel_e'(rd_sel))
        SEL_CFG:  rd_data <= 32'(cfg_q);
        SEL_ADDR: rd_data <= 32'(addr_q);
        SEL_DATA: rd_data <= 32'(data_q);
        default:  rd_data <= {busy, 29'd0, op_q};
      endcase
    end
  end

  mdm_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_q),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdm_engine u_engine (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_read (start_read),
    .pre_en     (cfg_q[CFG_PRE_EN]),
    .frame_word (frame_word),
    .rise       (rise),
    .fall       (fall),
    .mdi_bit    (mdi_bit),
    .busy       (busy),
    .rd_op      (rd_op),
    .done       (done),
    .rd_capt    (rd_capt),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker #(
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [31:0]     wr_data,
  input logic            cfg_ext,
  input logic            busy,
  input logic            rd_op,
  input logic [1:0]      op_q,
  input logic [DIVW-1:0] div_q,
  input logic            mdc,
  input logic            mdio_oe
);
  // R2: management clock parked low outside a frame
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R2: a high phase lasts more than one core clock when div is non-zero
  a_r2_high_phase: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(mdc) && (div_q != '0)) |=> mdc);

  // R4: a legal opcode written while idle starts a frame
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3 && !busy &&
     (cfg_ext || wr_data[1:0] == 2'd1 || wr_data[1:0] == 2'd2)) |=> busy);

  // R4: an illegal direct-mode opcode leaves the block idle
  a_r4_illegal_idle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3 && !busy && !cfg_ext &&
     (wr_data[1:0] == 2'd0 || wr_data[1:0] == 2'd3)) |=> !busy);

  // R5: line not driven when idle
  a_r5_oe_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R6: opcode writes during a frame leave the stored opcode alone
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_sel == 2'd3) |=> $stable(op_q));

  // R3: non-read frames drive the line for their whole length
  a_r3_write_driven: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_op) |-> mdio_oe);
endmodule

bind mgmt_mdio_master mdm_checker #(.DIVW(DIVW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .cfg_ext (cfg_ext),
  .busy    (busy),
  .rd_op   (rd_op),
  .op_q    (op_q),
  .div_q   (div_q),
  .mdc     (mdc),
  .mdio_oe (mdio_oe)
);

// File: tb/mgmt_mdio_master_tb.sv
`timescale 1ns/1ps
module mgmt_mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mgmt_mdio_master u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // flags {ext, pre, inv, mdi_en}, div, op, phy, reg, data, phy reply
  localparam logic [55:0] VEC [7] = '{
    {4'b0100, 8'd1, 2'd1, 5'h03, 5'h11, 16'hA5C3, 16'h0000},
    {4'b0101, 8'd2, 2'd2, 5'h1F, 5'h00, 16'h0000, 16'h1234},
    {4'b1000, 8'd0, 2'd0, 5'h0A, 5'h01, 16'h8001, 16'h0000},
    {4'b1100, 8'd3, 2'd1, 5'h15, 5'h1E, 16'hFFFF, 16'h0000},
    {4'b1011, 8'd1, 2'd3, 5'h02, 5'h07, 16'h0000, 16'h0F0F},
    {4'b0100, 8'd0, 2'd2, 5'h01, 5'h02, 16'h0000, 16'hBEEF},
    {4'b1001, 8'd0, 2'd2, 5'h11, 5'h13, 16'h0000, 16'h5A5A}
  };

  // bus monitor and PHY model
  int          cyc = 0, last_rise = 0, last_period = 0, rise_cnt = 0;
  int          cur_pre = 0;
  logic [15:0] cur_reply = '0;
  logic [63:0] seen_bits = '0, seen_oe = '0;
  logic        prev_mdc = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !prev_mdc) begin
      if (rise_cnt > 0) last_period = cyc - last_rise;
      last_rise = cyc;
      seen_bits = {seen_bits[62:0], mdio_o};
      seen_oe   = {seen_oe[62:0], mdio_oe};
      rise_cnt++;
      begin
        int pos;
        pos = rise_cnt - cur_pre;
        mdio_i = (pos >= 16 && pos < 32) ? cur_reply[31-pos] : 1'b1;
      end
    end
    prev_mdc = mdc;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); rd_sel = s;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    bit idle = 0;
    for (int n = 0; n < 4000 && !idle; n++) begin
      rd(2'd3, v);
      idle = !v[31];
    end
    chk(req, 64'(idle), 64'd1);
  endtask

  task automatic do_frame(input logic [55:0] vv, input bit poke);
    logic [3:0]  fl;  logic [7:0] dv; logic [1:0] op;
    logic [4:0]  phy, rg; logic [15:0] dat, rep, exp_data;
    logic [31:0] f32, v;
    logic [63:0] exp_bits, exp_oe;
    bit rdf;
    int nb;
    {fl, dv, op, phy, rg, dat, rep} = vv;
    rdf = fl[3] ? op[1] : (op == 2'd2);
    nb  = fl[2] ? 64 : 32;
    f32 = {fl[3] ? 2'b00 : 2'b01, op, phy, rg, rdf ? 2'b11 : 2'b10, rdf ? 16'h0 : dat};
    exp_bits = fl[2] ? {32'hFFFF_FFFF, f32} : {32'h0, f32};
    exp_oe   = (fl[2] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF) &
               ~(rdf ? 64'h3FFFF : 64'h0);
    exp_data = rdf ? (fl[0] ? (rep ^ (fl[1] ? 16'hFFFF : 16'h0)) : 16'h0) : dat;
    wr(2'd0, 32'(fl) | (32'(dv) << 5));
    wr(2'd1, {22'd0, phy, rg});
    wr(2'd2, {16'hDEAD, dat});
    cur_pre = fl[2] ? 32 : 0; cur_reply = rep;
    rise_cnt = 0; seen_bits = '0; seen_oe = '0;
    wr(2'd3, 32'(op));
    if (poke) begin
      rd(2'd3, v);
      chk("R5 busy set after start", 64'(v[31]), 64'd1);
      wr(2'd3, 32'd2);
      rd(2'd3, v);
      chk("R6 opcode kept during frame", 64'(v[1:0]), 64'(op));
    end
    wait_idle("R5 busy clears at frame end");
    chk("R3 bit count", 64'(rise_cnt), 64'(nb));
    chk("R3 driven bits", seen_bits & exp_oe, exp_bits & exp_oe);
    chk("R7 output enable pattern", seen_oe, exp_oe);
    chk("R2 mdc period", 64'(last_period), 64'(2 * (int'(dv) + 1)));
    rd(2'd2, v);
    chk(rdf ? "R7 R8 read data" : "R3 data kept", 64'(v), 64'(exp_data));
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 register reset", 64'(v), 64'd0);
    end
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 oe low", 64'(mdio_oe), 64'd0);

    // R9 readback widths
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R9 cfg readback", 64'(v), 64'h1FEF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R9 addr readback", 64'(v), 64'h3FF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R9 data readback", 64'(v), 64'hFFFF);

    // main vector table
    for (int i = 0; i < 7; i++) do_frame(VEC[i], 1'b0);

    // R4: direct mode opcodes 0 and 3 start nothing
    wr(2'd0, 32'h0000_0024);
    for (int k = 0; k < 2; k++) begin
      rise_cnt = 0;
      wr(2'd3, k == 0 ? 32'd0 : 32'd3);
      rd(2'd3, v);
      chk("R4 illegal opcode busy", 64'(v[31]), 64'd0);
      repeat (40) @(negedge clk);
      chk("R4 illegal opcode no clock", 64'(rise_cnt), 64'd0);
    end

    // R5 R6: opcode write during a running write frame
    do_frame({4'b0100, 8'd3, 2'd1, 5'h06, 5'h09, 16'h3C5A, 16'h0000}, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule